// File: doc/BRIEF.md
# Line-rate AIS clock generator with loss-of-clock supervision

This block derives two alarm-indication clocks, one at the DS1 line rate and one at the E1 line rate, from two reference inputs that each run at 16 or 32 times their own line rate. Both references are sampled into a single system-clock domain. Each divider advances only on a detected reference rising edge and toggles its output every half division, so the divided clocks have a 50% duty cycle. Both dividers always run, whatever the channels or the AIS enable are doing.

A bank of channel slices sits between a cross-connect and a jitter attenuator. A slice enters substitution when its own AIS request is high and the global AIS enable is set. While substituting, its output data is a constant one and its output clock is the divided AIS clock that matches its mode bit. Otherwise the slice passes its input clock and data through. The slice outputs are registered, so they lag the inputs by one system clock.

Each reference also has a loss-of-clock monitor. It is a three-state machine: `LM_LOST` is the reset state, `LM_VERIFY` counts consecutive edges, and `LM_ALIVE` means the clock is present. The transitions are: LOST→VERIFY on a reference edge; VERIFY→ALIVE on the edge that completes the acquire count; VERIFY→LOST when the gap timer expires; ALIVE→LOST when the gap timer expires. Every change of the loss status sets a sticky delta bit. An interrupt combines the status and delta bits that are not masked.

Top module: `ais_clock_gen`

## Requirements
- R1: Each divided AIS clock is high for half of its period. The period is 16 reference periods when its select bit in `ref_div32_i` is 0 and 32 reference periods when it is 1 (bit 0 selects for DS1, bit 1 for E1).
- R2: Both divided AIS clocks keep toggling when `ais_ctrl_en_i` is 0 and every channel is in E1 mode.
- R3: A channel substitutes only when `ais_ctrl_en_i` and its `chan_ais_req_i` bit are both 1. While it substitutes, its `chan_data_o` bit is 1 one system clock later.
- R4: A substituting channel's `chan_clk_o` follows, one system clock later, the DS1 AIS clock if its `chan_mode_ds1_i` bit is 1 and the E1 AIS clock if that bit is 0.
- R5: A channel that is not substituting outputs its `chan_clk_i` and `chan_data_i` bits one system clock later.
- R6: A loss flag (`loc_ds1_o`, `loc_e1_o`) becomes 1 when its reference shows no rising edge for 64 system clocks. A gap shorter than that keeps the flag at 0.
- R7: A loss flag returns to 0 after 8 consecutive reference edges, where each edge comes within 64 system clocks of the one before. A reference whose edges are spaced farther apart leaves the flag at 1.
- R8: `loc_delta_o` (bit 0 DS1, bit 1 E1) becomes 1 in the cycle its loss flag changes and holds. It clears on a one-cycle pulse on the same bit of `loc_delta_clr_i`. If a set and a clear fall in the same cycle, the set wins.
- R9: `irq_o` is 1 exactly when, for some reference, the loss flag or the delta bit is 1 and the `loc_mask_i` bit for that reference is 0.
- R10: During and right after reset, both AIS clocks and all channel outputs are 0, both loss flags are 1 and both delta bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_ds1_i | input | 1 | DS1 reference, 16x or 32x line rate |
| ref_e1_i | input | 1 | E1 reference, 16x or 32x line rate |
| ref_div32_i | input | 2 | Divide-by-32 select; bit 0 DS1, bit 1 E1 |
| ais_ctrl_en_i | input | 1 | Global AIS substitution enable |
| chan_mode_ds1_i | input | N_CHAN | Per-channel mode, 1 = DS1, 0 = E1 |
| chan_ais_req_i | input | N_CHAN | Per-channel AIS request |
| chan_clk_i | input | N_CHAN | Per-channel incoming clock |
| chan_data_i | input | N_CHAN | Per-channel incoming data |
| loc_mask_i | input | 2 | Interrupt mask, 1 = masked; bit 0 DS1, bit 1 E1 |
| loc_delta_clr_i | input | 2 | Write-one-to-clear strobe for the delta bits |
| ds1_ais_clk_o | output | 1 | Divided DS1 AIS clock |
| e1_ais_clk_o | output | 1 | Divided E1 AIS clock |
| chan_clk_o | output | N_CHAN | Per-channel outgoing clock |
| chan_data_o | output | N_CHAN | Per-channel outgoing data |
| loc_ds1_o | output | 1 | DS1 reference loss status |
| loc_e1_o | output | 1 | E1 reference loss status |
| loc_delta_o | output | 2 | Sticky loss-status change bits |
| irq_o | output | 1 | Unmasked loss interrupt |

## Verification
The hardest state to reach is a reference that never re-acquires. Its edges keep arriving, so the monitor keeps moving from LM_LOST into LM_VERIFY, but each gap is too long and the monitor falls back every time. The bench drives the DS1 reference with a 100-cycle period to hold the monitor in that loop. It then produces the acquire boundary by hand: seven edges, a pause shorter than the timeout, and an eighth edge, with the status sampled on both sides of that eighth edge. Random per-channel requests, modes and data, drawn under a toggling global enable, cover substitution against pass-through.

// File: rtl/ais_clkgen_pkg.sv
package ais_clkgen_pkg;

    // loss-of-clock monitor states
    typedef enum logic [1:0] {
        LM_LOST   = 2'd0,
        LM_VERIFY = 2'd1,
        LM_ALIVE  = 2'd2
    } loc_state_e;

    // reference index used across all two-bit vectors
    localparam int REF_DS1 = 0;
    localparam int REF_E1  = 1;
    localparam int N_REF   = 2;

endpackage

// File: rtl/ref_edge_sync.sv
module ref_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_i,
    output logic rise_o
);
    // STAGES flops for metastability, one more to find the edge
    logic [STAGES:0] shreg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) shreg <= '0;
        else        shreg <= {shreg[STAGES-1:0], ref_i};
    end

    always_comb rise_o = shreg[STAGES-1] & ~shreg[STAGES];

endmodule

// File: rtl/ais_divider.sv
module ais_divider #(
    parameter int DIV_LO = 16,
    parameter int DIV_HI = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rise_i,
    input  logic div_hi_i,
    output logic ais_clk_o
);
    localparam int HALF_LO = DIV_LO / 2;
    localparam int HALF_HI = DIV_HI / 2;
    localparam int CW      = $clog2(HALF_HI);

    logic [CW-1:0] edge_cnt;
    logic [CW-1:0] limit;
    logic          phase;

    always_comb limit = div_hi_i ? CW'(HALF_HI - 1) : CW'(HALF_LO - 1);

    // toggle once every half division of reference edges
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            edge_cnt <= '0;
            phase    <= 1'b0;
        end else if (rise_i) begin
            if (edge_cnt >= limit) begin
                edge_cnt <= '0;
                phase    <= ~phase;
            end else begin
                edge_cnt <= edge_cnt + 1'b1;
            end
        end
    end

    always_comb ais_clk_o = phase;

endmodule

// File: rtl/loc_monitor.sv
module loc_monitor
    import ais_clkgen_pkg::*;
#(
    parameter int TIMEOUT = 64,
    parameter int ACQ     = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rise_i,
    input  logic clr_i,
    output logic lost_o,
    output logic delta_o
);
    localparam int GW = $clog2(TIMEOUT);
    localparam int EW = $clog2(ACQ + 1);

    loc_state_e    state, state_nx;
    logic [GW-1:0] gap_cnt;
    logic [EW-1:0] acq_cnt;
    logic          expired;
    logic          delta_q;
    logic          status_flip;

    // gap timer: system cycles since the last reference edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                            gap_cnt <= '0;
        else if (rise_i)                       gap_cnt <= '0;
        else if (gap_cnt != GW'(TIMEOUT - 1))  gap_cnt <= gap_cnt + 1'b1;
    end

    always_comb expired = !rise_i && (gap_cnt == GW'(TIMEOUT - 1));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= LM_LOST;
        else        state <= state_nx;
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            LM_LOST: begin
                if (rise_i) state_nx = LM_VERIFY;
            end
            LM_VERIFY: begin
                if (rise_i && (acq_cnt == EW'(ACQ - 1))) state_nx = LM_ALIVE;
                else if (expired)                         state_nx = LM_LOST;
            end
            LM_ALIVE: begin
                if (expired) state_nx = LM_LOST;
            end
            default: state_nx = LM_LOST;
        endcase
    end

    // consecutive-edge counter used while verifying
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acq_cnt <= '0;
        end else begin
            unique case (state)
                LM_LOST:   acq_cnt <= rise_i ? EW'(1) : '0;
                LM_VERIFY: if (rise_i) acq_cnt <= acq_cnt + 1'b1;
                LM_ALIVE:  acq_cnt <= '0;
                default:   acq_cnt <= '0;
            endcase
        end
    end

    // sticky change flag, set takes priority over clear
    always_comb status_flip = (state == LM_ALIVE) != (state_nx == LM_ALIVE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) delta_q <= 1'b0;
        else        delta_q <= status_flip | (delta_q & ~clr_i);
    end

    // outputs
    always_comb begin
        lost_o  = (state != LM_ALIVE);
        delta_o = delta_q;
    end

endmodule

// File: rtl/ais_chan_slice.sv
module ais_chan_slice (
    input  logic clk,
    input  logic rst_n,
    input  logic ais_en_i,
    input  logic ais_req_i,
    input  logic mode_ds1_i,
    input  logic clk_in_i,
    input  logic data_in_i,
    input  logic ds1_ais_i,
    input  logic e1_ais_i,
    output logic clk_out_o,
    output logic data_out_o
);
    logic subst;
    logic ais_pick;

    always_comb begin
        subst    = ais_en_i & ais_req_i;
        ais_pick = mode_ds1_i ? ds1_ais_i : e1_ais_i;
    end

    // registered so the clock swap happens only on a system edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            clk_out_o  <= 1'b0;
            data_out_o <= 1'b0;
        end else begin
            clk_out_o  <= subst ? ais_pick : clk_in_i;
            data_out_o <= subst ? 1'b1     : data_in_i;
        end
    end

endmodule

// File: rtl/ais_clock_gen.sv
module ais_clock_gen
    import ais_clkgen_pkg::*;
#(
    parameter int N_CHAN      = 28,
    parameter int DIV_LO      = 16,
    parameter int DIV_HI      = 32,
    parameter int SYNC_STAGES = 2,
    parameter int LOC_TIMEOUT = 64,
    parameter int LOC_ACQ     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_ds1_i,
    input  logic              ref_e1_i,
    input  logic [1:0]        ref_div32_i,
    input  logic              ais_ctrl_en_i,
    input  logic [N_CHAN-1:0] chan_mode_ds1_i,
    input  logic [N_CHAN-1:0] chan_ais_req_i,
    input  logic [N_CHAN-1:0] chan_clk_i,
    input  logic [N_CHAN-1:0] chan_data_i,
    input  logic [1:0]        loc_mask_i,
    input  logic [1:0]        loc_delta_clr_i,
    output logic              ds1_ais_clk_o,
    output logic              e1_ais_clk_o,
    output logic [N_CHAN-1:0] chan_clk_o,
    output logic [N_CHAN-1:0] chan_data_o,
    output logic              loc_ds1_o,
    output logic              loc_e1_o,
    output logic [1:0]        loc_delta_o,
    output logic              irq_o
);
    logic [N_REF-1:0] ref_vec;
    logic [N_REF-1:0] ref_rise;
    logic [N_REF-1:0] ais_clk;
    logic [N_REF-1:0] lost;
    logic [N_REF-1:0] delta;

    always_comb begin
        ref_vec[REF_DS1] = ref_ds1_i;
        ref_vec[REF_E1]  = ref_e1_i;
    end

    for (genvar r = 0; r < N_REF; r++) begin : g_ref
        ref_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk    (clk),
            .rst_n  (rst_n),
            .ref_i  (ref_vec[r]),
            .rise_o (ref_rise[r])
        );

        ais_divider #(.DIV_LO(DIV_LO), .DIV_HI(DIV_HI)) u_div (
            .clk       (clk),
            .rst_n     (rst_n),
            .rise_i    (ref_rise[r]),
            .div_hi_i  (ref_div32_i[r]),
            .ais_clk_o (ais_clk[r])
        );

        loc_monitor #(.TIMEOUT(LOC_TIMEOUT), .ACQ(LOC_ACQ)) u_loc (
            .clk     (clk),
            .rst_n   (rst_n),
            .rise_i  (ref_rise[r]),
            .clr_i   (loc_delta_clr_i[r]),
            .lost_o  (lost[r]),
            .delta_o (delta[r])
        );
    end

    for (genvar c = 0; c < N_CHAN; c++) begin : g_chan
        ais_chan_slice u_slice (
            .clk        (clk),
            .rst_n      (rst_n),
            .ais_en_i   (ais_ctrl_en_i),
            .ais_req_i  (chan_ais_req_i[c]),
            .mode_ds1_i (chan_mode_ds1_i[c]),
            .clk_in_i   (chan_clk_i[c]),
            .data_in_i  (chan_data_i[c]),
            .ds1_ais_i  (ais_clk[REF_DS1]),
            .e1_ais_i   (ais_clk[REF_E1]),
            .clk_out_o  (chan_clk_o[c]),
            .data_out_o (chan_data_o[c])
        );
    end

    always_comb begin
        ds1_ais_clk_o = ais_clk[REF_DS1];
        e1_ais_clk_o  = ais_clk[REF_E1];
        loc_ds1_o     = lost[REF_DS1];
        loc_e1_o      = lost[REF_E1];
        loc_delta_o   = delta;
        irq_o         = |((lost | delta) & ~loc_mask_i);
    end

endmodule

// File: rtl/ais_clock_gen_chk.sv
module ais_clock_gen_chk #(
    parameter int N_CHAN = 28
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ais_ctrl_en_i,
    input logic [N_CHAN-1:0] chan_mode_ds1_i,
    input logic [N_CHAN-1:0] chan_ais_req_i,
    input logic [N_CHAN-1:0] chan_data_i,
    input logic [1:0]        loc_mask_i,
    input logic              ds1_ais_clk_o,
    input logic              e1_ais_clk_o,
    input logic [N_CHAN-1:0] chan_clk_o,
    input logic [N_CHAN-1:0] chan_data_o,
    input logic              loc_ds1_o,
    input logic              loc_e1_o,
    input logic [1:0]        loc_delta_o,
    input logic              irq_o
);
    for (genvar g = 0; g < N_CHAN; g++) begin : g_c
        p_ais_ones_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (ais_ctrl_en_i && chan_ais_req_i[g]) |=> chan_data_o[g]);

        p_ds1_clk_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (ais_ctrl_en_i && chan_ais_req_i[g] && chan_mode_ds1_i[g])
            |=> (chan_clk_o[g] == $past(ds1_ais_clk_o)));

        p_e1_clk_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (ais_ctrl_en_i && chan_ais_req_i[g] && !chan_mode_ds1_i[g])
            |=> (chan_clk_o[g] == $past(e1_ais_clk_o)));

        p_pass_data_r5: assert property (@(posedge clk) disable iff (!rst_n)
            !(ais_ctrl_en_i && chan_ais_req_i[g])
            |=> (chan_data_o[g] == $past(chan_data_i[g])));
    end

    p_ds1_delta_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (loc_ds1_o != $past(loc_ds1_o)) |-> loc_delta_o[0]);

    p_e1_delta_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (loc_e1_o != $past(loc_e1_o)) |-> loc_delta_o[1]);

    p_masked_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (&loc_mask_i) |-> !irq_o);

    p_unmasked_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((loc_ds1_o || loc_delta_o[0]) && !loc_mask_i[0]) |-> irq_o);

endmodule

bind ais_clock_gen ais_clock_gen_chk #(.N_CHAN(N_CHAN)) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .ais_ctrl_en_i   (ais_ctrl_en_i),
    .chan_mode_ds1_i (chan_mode_ds1_i),
    .chan_ais_req_i  (chan_ais_req_i),
    .chan_data_i     (chan_data_i),
    .loc_mask_i      (loc_mask_i),
    .ds1_ais_clk_o   (ds1_ais_clk_o),
    .e1_ais_clk_o    (e1_ais_clk_o),
    .chan_clk_o      (chan_clk_o),
    .chan_data_o     (chan_data_o),
    .loc_ds1_o       (loc_ds1_o),
    .loc_e1_o        (loc_e1_o),
    .loc_delta_o     (loc_delta_o),
    .irq_o           (irq_o)
);

// File: tb/ais_clock_gen_bench.sv
`timescale 1ns/1ps
module ais_clock_gen_bench;
    localparam int NC = 28;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ref_ds1 = 1'b0, ref_e1 = 1'b0;
    logic [1:0]    div32 = 2'b00;
    logic          ais_en = 1'b0;
    logic [NC-1:0] mode = '0, req = '0, cin = '0, din = '0;
    logic [1:0]    mask = 2'b00, clr = 2'b00;
    logic          ds1_ais, e1_ais, loc_ds1, loc_e1, irq;
    logic [NC-1:0] cout, dout;
    logic [1:0]    delta;

    int n_chk = 0, n_bad = 0;

    // reference generators: half period in system cycles, or manual level
    bit ds1_run = 0, e1_run = 0;
    bit ds1_man = 0;
    int ds1_half = 2, e1_half = 3;

    always #4 clk = ~clk;

    ais_clock_gen #(.N_CHAN(NC)) u_ais_clock_gen (
        .clk(clk), .rst_n(rst_n), .ref_ds1_i(ref_ds1), .ref_e1_i(ref_e1),
        .ref_div32_i(div32), .ais_ctrl_en_i(ais_en), .chan_mode_ds1_i(mode),
        .chan_ais_req_i(req), .chan_clk_i(cin), .chan_data_i(din),
        .loc_mask_i(mask), .loc_delta_clr_i(clr), .ds1_ais_clk_o(ds1_ais),
        .e1_ais_clk_o(e1_ais), .chan_clk_o(cout), .chan_data_o(dout),
        .loc_ds1_o(loc_ds1), .loc_e1_o(loc_e1), .loc_delta_o(delta), .irq_o(irq)
    );

    initial begin : gen_ds1
        int cnt = 0;
        forever begin
            @(negedge clk);
            if (ds1_run) begin
                if (cnt >= ds1_half - 1) begin cnt = 0; ref_ds1 = ~ref_ds1; end
                else cnt++;
            end else begin
                cnt = 0; ref_ds1 = ds1_man;
            end
        end
    end

    initial begin : gen_e1
        int cnt = 0;
        forever begin
            @(negedge clk);
            if (e1_run) begin
                if (cnt >= e1_half - 1) begin cnt = 0; ref_e1 = ~ref_e1; end
                else cnt++;
            end else begin
                cnt = 0; ref_e1 = 1'b0;
            end
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wait_neg(input int n);
        repeat (n) @(negedge clk);
    endtask

    // expected values derived from the requirements
    function automatic bit exp_data(bit en, bit rq, bit d);
        return (en && rq) ? 1'b1 : d;
    endfunction

    function automatic bit exp_clk(bit en, bit rq, bit md, bit c, bit a_ds1, bit a_e1);
        if (en && rq) return md ? a_ds1 : a_e1;
        return c;
    endfunction

    function automatic bit exp_irq(bit l0, bit l1, bit [1:0] dl, bit [1:0] mk);
        return ((l0 | dl[0]) & ~mk[0]) | ((l1 | dl[1]) & ~mk[1]);
    endfunction

    // measure high time and period of a divided clock, sampled at negedges
    task automatic measure(input bit pick_e1, output int hi, output int per);
        int guard = 0;
        bit cur, prv;
        hi = 0; per = 0;
        prv = pick_e1 ? e1_ais : ds1_ais;
        forever begin
            @(negedge clk); cur = pick_e1 ? e1_ais : ds1_ais; guard++;
            if (cur && !prv) break;
            prv = cur;
            if (guard > 2000) return;
        end
        per = 1; hi = 1; prv = 1'b1;
        forever begin
            @(negedge clk); cur = pick_e1 ? e1_ais : ds1_ais;
            if (cur && !prv) break;
            per++;
            if (cur) hi++;
            prv = cur;
            if (per > 2000) return;
        end
    endtask

    task automatic random_phase(input int cycles);
        bit p_en; bit [NC-1:0] p_rq, p_md, p_c, p_d; bit p_a1, p_a2;
        void'($urandom(32'd20240611));
        for (int k = 0; k < cycles; k++) begin
            @(negedge clk);
            if (k > 0) begin
                for (int i = 0; i < NC; i++) begin
                    // R3 / R4 / R5 checks per channel
                    chk("R3R5 data", dout[i], exp_data(p_en, p_rq[i], p_d[i]));
                    chk("R4R5 clk", cout[i],
                        exp_clk(p_en, p_rq[i], p_md[i], p_c[i], p_a1, p_a2));
                end
            end
            p_a1 = ds1_ais; p_a2 = e1_ais;
            if ((k % 37) == 0) ais_en = $urandom_range(0, 1);
            req  = NC'($urandom()); mode = NC'($urandom());
            cin  = NC'($urandom()); din  = NC'($urandom());
            if ((k % 53) == 0) req = '1;
            p_en = ais_en; p_rq = req; p_md = mode; p_c = cin; p_d = din;
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_bad++; n_chk++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        int hi, per;
        // R10: reset state
        wait_neg(4);
        chk("R10 ds1 ais", ds1_ais, 0);
        chk("R10 e1 ais", e1_ais, 0);
        chk("R10 loc ds1", loc_ds1, 1);
        chk("R10 loc e1", loc_e1, 1);
        chk("R10 delta", delta, 0);
        chk("R10 chan data", dout, 0);
        rst_n = 1'b1;
        wait_neg(3);
        chk("R10 after reset loc ds1", loc_ds1, 1);
        chk("R10 after reset delta", delta, 0);

        // R7: both references acquire
        ds1_run = 1; e1_run = 1;
        wait_neg(200);
        chk("R7 ds1 acquired", loc_ds1, 0);
        chk("R7 e1 acquired", loc_e1, 0);
        chk("R8 delta set on acquire", delta, 3);
        clr = 2'b11; wait_neg(1); clr = 2'b00; wait_neg(1);
        chk("R8 delta cleared", delta, 0);
        chk("R9 quiet irq", irq, 0);

        // R1 / R2: divide by 16, enable off, all channels E1
        ais_en = 0; mode = '0;
        measure(0, hi, per);
        chk("R1 R2 ds1 /16 period", per, 64);
        chk("R1 ds1 /16 high", hi, 32);
        measure(1, hi, per);
        chk("R1 R2 e1 /16 period", per, 96);
        chk("R1 e1 /16 high", hi, 48);

        // R1: divide by 32
        div32 = 2'b11;
        wait_neg(300);
        measure(0, hi, per);
        chk("R1 ds1 /32 period", per, 128);
        chk("R1 ds1 /32 high", hi, 64);
        measure(1, hi, per);
        chk("R1 e1 /32 period", per, 192);
        chk("R1 e1 /32 high", hi, 96);
        div32 = 2'b00;

        // R3 / R4 / R5 random channel traffic
        random_phase(400);
        ais_en = 0;

        // R6: gap below and above the timeout
        ds1_run = 0; ds1_man = 0;
        wait_neg(40);
        chk("R6 short gap keeps clock", loc_ds1, 0);
        wait_neg(60);
        chk("R6 long gap declares loss", loc_ds1, 1);
        chk("R8 delta on loss", delta[0], 1);
        chk("R9 irq unmasked", irq, exp_irq(loc_ds1, loc_e1, delta, 2'b00));
        mask = 2'b01; wait_neg(1);
        chk("R9 irq masked ds1", irq, exp_irq(loc_ds1, loc_e1, delta, 2'b01));
        mask = 2'b10; wait_neg(1);
        chk("R9 irq masked e1 only", irq, 1);
        mask = 2'b00;

        // R7: edges too sparse never acquire
        ds1_half = 50; ds1_run = 1;
        for (int j = 0; j < 6; j++) begin
            wait_neg(100);
            chk("R7 sparse edges stay lost", loc_ds1, 1);
        end

        // R7: seventh versus eighth edge
        ds1_run = 0; ds1_man = 0; ds1_half = 2;
        wait_neg(100);
        clr = 2'b01; wait_neg(1); clr = 2'b00; wait_neg(1);
        chk("R8 delta clear after sparse", delta[0], 0);
        for (int j = 0; j < 7; j++) begin
            ds1_man = 1; wait_neg(2); ds1_man = 0; wait_neg(2);
        end
        wait_neg(20);
        chk("R7 seven edges still lost", loc_ds1, 1);
        ds1_man = 1; wait_neg(10);
        chk("R7 eighth edge clears loss", loc_ds1, 0);
        chk("R8 delta on reacquire", delta[0], 1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule